// File: doc/BRIEF.md
# Banked Memory Address Mapper

This block sits between an 8-bit CPU's 16-bit address bus and three physical stores: a 512KB SRAM, a 4MB Flash and a 1KB on-chip boot ROM. For every CPU address it reports which store is hit and the physical byte address inside that store. It also reports whether a write there is allowed, and whether the access goes to Flash. A clock controller uses the Flash signal to slow the CPU.

The mapping is set by a control byte and two window registers, all written and read over the CPU's I/O space. The control byte picks one of two complete layouts. The normal layout has ROMs in the low 16KB and paged RAM above. The CP/M layout has RAM in every slot. The byte also carries a ROM number and a RAM page number. RAM pages 14 and 15 open windows onto any raw 16KB SRAM page, and page 15 also opens a window onto any Flash page. After reset the control byte selects the CP/M layout with page 15, so the first instruction fetch comes from the boot ROM.

Top module: `banked_mapper`

## Requirements
- R1: On reset the control byte reads 0x8F and both window registers read 0x00. With that state, address 0x0000 maps to the boot ROM at offset 0.
- R2: I/O writes to port 0x00 (control), 0xD0 (window 1) and 0xD1 (window 2) take effect on the next clock edge. All three read back in full. Any other port reads 0xFF and has no effect when written. The control byte layout is: bit 7 = CP/M layout, bits 6..4 = ROM number, bits 3..0 = RAM page.
- R3: In the normal layout, 0x0000–0x1FFF maps to the SRAM byte 0x20000+offset. 0x2000–0x3FFF maps to SRAM 0x10000 + ROM number×0x2000 + (address & 0x1FFF). Both regions are read-only, and RAM page 14 or 15 does not change them.
- R4: In the normal layout, page 0 maps 0x4000 to SRAM page 2 and 0x8000 to SRAM page 1. For pages 1–11, slot 0x8000 takes list entry 2P−1 and slot 0x4000 takes entry 2P. Entry 1 is SRAM page 3, and entry n≥2 is SRAM page n+10. Entry 22 does not exist.
- R5: A slot with no page has target code 0 and is neither writable nor Flash. This covers normal pages 12–13 below 0xC000 (except the ROM area) and CP/M pages 8–13 below 0xC000.
- R6: 0xC000–0xFFFF always maps to SRAM page 0 and is writable.
- R7: In the CP/M layout, page 0 maps slots 0x0000/0x4000/0x8000 to SRAM pages 3/2/1. Page P in 1–7 maps slot s (0..2) to SRAM page 0x0C+3(P−1)+s, and entries past SRAM page 0x1F are unmapped.
- R8: With page 14 in either layout, 0x4000 shows SRAM page window1[4:0] and 0x8000 shows SRAM page window2[4:0]. Both are writable.
- R9: With page 15, 0x4000 shows SRAM page window1[4:0] (writable). 0x8000 shows Flash byte window2×0x4000 + offset, and this Flash region is read-only.
- R10: With page 15 in the CP/M layout, 0x0000–0x3FFF maps to the boot ROM at address bits 9..0, so the ROM repeats every 1KB. The region is read-only.
- R11: The Flash flag is high exactly when the target code is 2. Target codes are 0 none, 1 SRAM, 2 Flash, 3 boot ROM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe |
| io_port | input | 8 | I/O port number |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Read-back of the addressed register, 0xFF if none |
| cpu_addr | input | 16 | CPU logical address |
| tgt | output | 2 | Target code: 0 none, 1 SRAM, 2 Flash, 3 boot ROM |
| phys_addr | output | 22 | Physical byte address inside the target |
| wr_ok | output | 1 | A write at this address is allowed |
| flash_active | output | 1 | Access goes to Flash |

## Verification
The state is only three registers, and every output is combinational from them and the address. A corrupted control or window byte therefore shows up in the same cycle: a wrong target, a wrong page in the upper physical address bits, or a wrong write permission. The bench walks each page of both layouts at slot boundaries. Errors in the list-index arithmetic show up as an off-by-one page, or as a slot that should be unmapped but is not, at pages 1, 11, 7 and beyond.

// File: rtl/banked_mapper.sv
module banked_mapper #(
  parameter logic [7:0] CTRL_PORT  = 8'h00,
  parameter logic [7:0] PG1_PORT   = 8'hD0,
  parameter logic [7:0] PG2_PORT   = 8'hD1,
  parameter logic [7:0] CTRL_RESET = 8'h8F,
  parameter int         PA_W       = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            io_wr,
  input  logic [7:0]      io_port,
  input  logic [7:0]      io_wdata,
  output logic [7:0]      io_rdata,
  input  logic [15:0]     cpu_addr,
  output logic [1:0]      tgt,
  output logic [PA_W-1:0] phys_addr,
  output logic            wr_ok,
  output logic            flash_active
);
  localparam logic [1:0] T_NONE = 2'd0, T_SRAM = 2'd1, T_FLASH = 2'd2, T_BOOT = 2'd3;
  localparam int OFF_W = 14;
  localparam int SPG_W = 5;
  localparam logic [SPG_W-1:0] LAST_PG = '1;

  logic [7:0] ctrl_q, pg1_q, pg2_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
      pg1_q  <= '0;
      pg2_q  <= '0;
    end else if (io_wr) begin
      if (io_port == CTRL_PORT) ctrl_q <= io_wdata;
      else if (io_port == PG1_PORT) pg1_q <= io_wdata;
      else if (io_port == PG2_PORT) pg2_q <= io_wdata;
    end

  assign io_rdata = (io_port == CTRL_PORT) ? ctrl_q :
                    (io_port == PG1_PORT)  ? pg1_q  :
                    (io_port == PG2_PORT)  ? pg2_q  : 8'hFF;

  wire             cpm  = ctrl_q[7];
  wire [2:0]       rsel = ctrl_q[6:4];
  wire [3:0]       pg   = ctrl_q[3:0];
  wire [1:0]       slot = cpu_addr[15:14];
  wire [OFF_W-1:0] off  = cpu_addr[OFF_W-1:0];

  logic [SPG_W-1:0] spg;
  logic             use_pg;
  logic [5:0]       idx;

  always_comb begin
    tgt       = T_NONE;
    phys_addr = '0;
    wr_ok     = 1'b0;
    spg       = '0;
    use_pg    = 1'b0;
    idx       = '0;
    if (slot == 2'd3) begin
      use_pg = 1'b1;
    end else if (pg == 4'd14 && slot != 2'd0) begin
      use_pg = 1'b1;
      spg    = (slot == 2'd1) ? pg1_q[SPG_W-1:0] : pg2_q[SPG_W-1:0];
    end else if (pg == 4'd15 && slot == 2'd1) begin
      use_pg = 1'b1;
      spg    = pg1_q[SPG_W-1:0];
    end else if (pg == 4'd15 && slot == 2'd2) begin
      tgt       = T_FLASH;
      phys_addr = PA_W'({pg2_q, off});
    end else if (!cpm) begin
      if (slot == 2'd0) begin
        tgt = T_SRAM;
        if (!off[13]) phys_addr = PA_W'({5'h08, 1'b0, off[12:0]});
        else          phys_addr = PA_W'({3'b001, rsel, off[12:0]});
      end else if (pg == 4'd0) begin
        use_pg = 1'b1;
        spg    = (slot == 2'd1) ? 5'd2 : 5'd1;
      end else if (pg <= 4'd11) begin
        idx = 6'({pg, 1'b0}) - 6'(slot[1]);
        if (idx == 6'd1) begin
          use_pg = 1'b1;
          spg    = 5'd3;
        end else if (idx <= 6'd21) begin
          use_pg = 1'b1;
          spg    = 5'(idx + 6'd10);
        end
      end
    end else begin
      if (pg == 4'd15 && slot == 2'd0) begin
        tgt       = T_BOOT;
        phys_addr = PA_W'(off[9:0]);
      end else if (pg == 4'd0) begin
        use_pg = 1'b1;
        spg    = 5'(2'd3 - slot);
      end else if (pg <= 4'd7) begin
        idx = 6'((pg - 4'd1) * 3) + 6'(slot);
        if (idx + 6'd12 <= 6'(LAST_PG)) begin
          use_pg = 1'b1;
          spg    = 5'(idx + 6'd12);
        end
      end
    end
    if (use_pg) begin
      tgt       = T_SRAM;
      phys_addr = PA_W'({spg, off});
      wr_ok     = 1'b1;
    end
  end

  assign flash_active = (tgt == T_FLASH);
endmodule

module banked_mapper_chk #(
  parameter logic [7:0] PG1_PORT = 8'hD0,
  parameter int         PA_W     = 22
) (
  input logic            clk,
  input logic            rst_n,
  input logic            io_wr,
  input logic [7:0]      io_port,
  input logic [7:0]      io_wdata,
  input logic [15:0]     cpu_addr,
  input logic [1:0]      tgt,
  input logic [PA_W-1:0] phys_addr,
  input logic            wr_ok,
  input logic            flash_active,
  input logic [7:0]      ctrl_q,
  input logic [7:0]      pg2_q,
  input logic [7:0]      pg1_q
);
  // R6
  common_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[15:14] == 2'd3 |-> tgt == 2'd1 && phys_addr == PA_W'(cpu_addr[13:0]) && wr_ok);
  // R5
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt == 2'd0 |-> !wr_ok && !flash_active);
  // R9
  flash_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt == 2'd2 |-> !wr_ok && phys_addr[21:14] == pg2_q && ctrl_q[3:0] == 4'd15);
  // R10
  boot_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt == 2'd3 |-> ctrl_q[7] && ctrl_q[3:0] == 4'd15 && cpu_addr[15:14] == 2'd0
                    && phys_addr[PA_W-1:10] == '0 && !wr_ok);
  // R8
  window_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr && io_port == PG1_PORT |=> pg1_q == $past(io_wdata));
endmodule

bind banked_mapper banked_mapper_chk #(.PG1_PORT(PG1_PORT), .PA_W(PA_W)) chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_port(io_port), .io_wdata(io_wdata),
  .cpu_addr(cpu_addr), .tgt(tgt), .phys_addr(phys_addr), .wr_ok(wr_ok),
  .flash_active(flash_active), .ctrl_q(ctrl_q), .pg2_q(pg2_q), .pg1_q(pg1_q));

// File: tb/banked_mapper_test.sv
module banked_mapper_test;
  logic clk = 0, rst_n = 0;
  logic io_wr = 0;
  logic [7:0] io_port = 8'h55, io_wdata = 0, io_rdata;
  logic [15:0] cpu_addr = 0;
  logic [1:0] tgt;
  logic [21:0] phys_addr;
  logic wr_ok, flash_active;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  banked_mapper uut (.clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_port(io_port),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cpu_addr(cpu_addr), .tgt(tgt),
    .phys_addr(phys_addr), .wr_ok(wr_ok), .flash_active(flash_active));

  typedef struct packed { logic [1:0] t; logic [21:0] a; logic w; logic [15:0] ca; } exp_t;
  exp_t q[$];
  string tagq[$];

  task automatic probe(input logic [15:0] ca, input logic [1:0] t, input logic [21:0] a,
                       input logic w, input string tag);
    exp_t e;
    @(posedge clk); #1;
    cpu_addr = ca;
    e.t = t; e.a = a; e.w = w; e.ca = ca;
    q.push_back(e);
    tagq.push_back(tag);
  endtask

  always @(negedge clk) if (q.size() > 0) begin
    exp_t e;
    string tg;
    e = q.pop_front();
    tg = tagq.pop_front();
    checks++;
    if (tgt !== e.t || (e.t != 0 && phys_addr !== e.a) || wr_ok !== e.w
        || flash_active !== (e.t == 2'd2)) begin
      errors++;
      $display("FAIL %s addr=%h got t=%0d pa=%h w=%b f=%b exp t=%0d pa=%h w=%b f=%b",
               tg, e.ca, tgt, phys_addr, wr_ok, flash_active, e.t, e.a, e.w, e.t == 2'd2);
    end
  end

  task automatic io_write(input logic [7:0] p, input logic [7:0] d);
    @(posedge clk); #1;
    io_wr = 1; io_port = p; io_wdata = d;
    @(posedge clk); #1;
    io_wr = 0; io_port = 8'h55;
  endtask

  task automatic rd_check(input logic [7:0] p, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    io_port = p;
    @(negedge clk);
    checks++;
    if (io_rdata !== exp) begin
      errors++;
      $display("FAIL %s port=%h got=%h exp=%h", tag, p, io_rdata, exp);
    end
  endtask

  function automatic logic [21:0] sp(input logic [4:0] pg, input logic [15:0] a);
    return {3'b0, pg, a[13:0]};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd_check(8'h00, 8'h8F, "R1 ctrl reset");
    rd_check(8'hD0, 8'h00, "R1 win1 reset");
    rd_check(8'hD1, 8'h00, "R1 win2 reset");
    probe(16'h0000, 2'd3, 22'h0, 0, "R1 boot fetch");
    probe(16'h0123, 2'd3, 22'h123, 0, "R10 boot");
    probe(16'h3D23, 2'd3, 22'h123, 0, "R10 boot repeat");
    probe(16'h8010, 2'd2, 22'h10, 0, "R9 flash page 0");
    probe(16'hC123, 2'd1, 22'h123, 1, "R6 common");

    rd_check(8'h55, 8'hFF, "R2 unused port read");
    io_write(8'h55, 8'h00);
    rd_check(8'h00, 8'h8F, "R2 unused port write ignored");
    io_write(8'hD0, 8'h13);
    io_write(8'hD1, 8'hA7);
    rd_check(8'hD0, 8'h13, "R2 win1 readback");
    rd_check(8'hD1, 8'hA7, "R2 win2 readback");
    probe(16'h4005, 2'd1, 22'h4C005, 1, "R9 sram window");
    probe(16'h8000, 2'd2, 22'h29C000, 0, "R9 flash window");

    io_write(8'h00, 8'h01);
    rd_check(8'h00, 8'h01, "R2 ctrl readback");
    probe(16'h0000, 2'd1, 22'h20000, 0, "R3 OS start");
    probe(16'h1FFF, 2'd1, 22'h21FFF, 0, "R3 OS end");
    probe(16'h2000, 2'd1, 22'h10000, 0, "R3 ROM 0");
    probe(16'h4000, 2'd1, sp(5'h0C, 16'h4000), 1, "R4 P1 0x4000");
    probe(16'h8000, 2'd1, sp(5'h03, 16'h8000), 1, "R4 P1 0x8000");
    probe(16'hFFFF, 2'd1, 22'h3FFF, 1, "R6 common top");

    io_write(8'h00, 8'h52);
    probe(16'h2010, 2'd1, 22'h1A010, 0, "R3 ROM 5");
    probe(16'h4000, 2'd1, sp(5'h0E, 16'h4000), 1, "R4 P2 0x4000");
    probe(16'h8001, 2'd1, sp(5'h0D, 16'h8001), 1, "R4 P2 0x8000");

    io_write(8'h00, 8'h00);
    probe(16'h4000, 2'd1, sp(5'h02, 16'h4000), 1, "R4 P0 0x4000");
    probe(16'hBFFF, 2'd1, sp(5'h01, 16'hBFFF), 1, "R4 P0 0x8000");

    io_write(8'h00, 8'h0B);
    probe(16'h8000, 2'd1, sp(5'h1F, 16'h8000), 1, "R4 P11 0x8000");
    probe(16'h4000, 2'd0, 22'h0, 0, "R4 R5 P11 0x4000 unmapped");

    io_write(8'h00, 8'h0C);
    probe(16'h4000, 2'd0, 22'h0, 0, "R5 P12 0x4000");
    probe(16'h8000, 2'd0, 22'h0, 0, "R5 P12 0x8000");

    io_write(8'h00, 8'h0E);
    probe(16'h0000, 2'd1, 22'h20000, 0, "R3 OS under P14");
    probe(16'h4005, 2'd1, 22'h4C005, 1, "R8 P14 win1");
    probe(16'h8000, 2'd1, sp(5'h07, 16'h8000), 1, "R8 P14 win2 low bits");

    io_write(8'h00, 8'h0F);
    probe(16'h2000, 2'd1, 22'h10000, 0, "R3 ROM under P15");
    probe(16'hA000, 2'd2, 22'h29E000, 0, "R9 R11 flash normal layout");

    io_write(8'h00, 8'h80);
    probe(16'h0000, 2'd1, sp(5'h03, 16'h0000), 1, "R7 cpm P0 slot0");
    probe(16'h4000, 2'd1, sp(5'h02, 16'h4000), 1, "R7 cpm P0 slot1");
    probe(16'h8000, 2'd1, sp(5'h01, 16'h8000), 1, "R7 cpm P0 slot2");

    io_write(8'h00, 8'h81);
    probe(16'h0100, 2'd1, sp(5'h0C, 16'h0100), 1, "R7 cpm P1 slot0");
    probe(16'h4000, 2'd1, sp(5'h0D, 16'h4000), 1, "R7 cpm P1 slot1");
    probe(16'h8000, 2'd1, sp(5'h0E, 16'h8000), 1, "R7 cpm P1 slot2");

    io_write(8'h00, 8'h87);
    probe(16'h0000, 2'd1, sp(5'h1E, 16'h0000), 1, "R7 cpm P7 slot0");
    probe(16'h4000, 2'd1, sp(5'h1F, 16'h4000), 1, "R7 cpm P7 slot1");
    probe(16'h8000, 2'd0, 22'h0, 0, "R7 R5 cpm P7 slot2 unmapped");

    io_write(8'h00, 8'h88);
    probe(16'h0000, 2'd0, 22'h0, 0, "R5 cpm P8 slot0");
    probe(16'hC000, 2'd1, 22'h0, 1, "R6 common cpm");

    io_write(8'h00, 8'h8E);
    probe(16'h0000, 2'd0, 22'h0, 0, "R5 cpm P14 slot0");
    probe(16'h4000, 2'd1, 22'h4C000, 1, "R8 cpm P14 win1");

    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule